// File: doc/BRIEF.md
# Debug Breakpoint Comparator Unit

This block watches two address streams of a CPU, the instruction-fetch address and the load/store data address, and raises a break request toward a debug controller. It has two fixed program-address comparators and two shared comparator slots. A mode field lets each shared slot compare program or data addresses. The mode field can also fuse the two shared slots into one masked range comparator. The block can also break on every executed instruction (single step) and on every instruction that leaves sequential program flow.

The debug side programs the unit through a narrow synchronous register write port. Each break source sets its own sticky bit in a status vector. The break request is the OR of those bits. The debug side clears bits by writing ones to the clear register. Comparisons go through one register stage, so a break request shows one clock after the strobe that caused it.

Top module: `brk_unit`

## Requirements
- R1: After reset every configuration register is zero, so all comparators and both step modes are disabled, `brk_src_o` is 0 and `brk_o` is low.
- R2: Register 1 and register 2 hold the references of fixed program comparators 0 and 1. Ctrl (register 0) bits 0 and 1 enable them. An enabled comparator sets `brk_src_o[0]` or `brk_src_o[1]` when `fetch_valid_i` is high and `fetch_addr_i` equals its reference.
- R3: Ctrl bits [8:6] select how the shared slots are used. 0 makes both program comparators. 1 makes slot 0 program and slot 1 data. 2 makes both data comparators. 3 gives a program range. 4 gives a data range. Codes 5 to 7 are illegal, and with an illegal code neither shared slot ever matches.
- R4: A shared slot in program use compares `fetch_addr_i` with all 17 bits of its register (3 for slot 0, 4 for slot 1) on `fetch_valid_i`. On a match it sets `brk_src_o[2]` for slot 0 or `brk_src_o[3]` for slot 1.
- R5: A shared slot in data use compares `dacc_addr_i` with the low 16 bits of its register on `dacc_valid_i`. The access must also pass the slot's qualifier: ctrl [10:9] for slot 0 and [12:11] for slot 1. Qualifier bit 0 allows reads (`dacc_we_i` low) and bit 1 allows writes. 00 never matches and 11 matches either.
- R6: In range mode, register 3 is the reference and register 4 is the mask. A hit needs (addr & mask) == (ref & mask). It is gated by the slot 0 enable and, for data, by the slot 0 qualifier. It is reported only on `brk_src_o[2]`, and `brk_src_o[3]` never sets.
- R7: A comparator whose enable bit is clear never sets its status bit. Ctrl bit 2 enables slot 0 and ctrl bit 3 enables slot 1.
- R8: With ctrl bit 4 set, an `exec_valid_i` with `exec_flow_i` high sets `brk_src_o[4]`. With ctrl bit 5 set, every `exec_valid_i` sets `brk_src_o[5]`.
- R9: Status bits are sticky. `brk_o` is high while any status bit is set. Writing register 5 clears exactly the status bits whose data bit is 1.
- R10: A hit in the same cycle as a clear of that bit leaves the bit set.
- R11: A status bit rises on the clock edge that samples the hit strobe, so it is first visible one clock after the strobe. A configuration write takes effect for strobes in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 17 | Configuration write data |
| fetch_valid_i | input | 1 | Instruction fetch address valid |
| fetch_addr_i | input | 17 | Instruction fetch word address |
| exec_valid_i | input | 1 | An instruction completed this cycle |
| exec_flow_i | input | 1 | That instruction left sequential flow |
| dacc_valid_i | input | 1 | Data access valid |
| dacc_we_i | input | 1 | Data access is a write |
| dacc_addr_i | input | 16 | Data access address |
| brk_o | output | 1 | Break request |
| brk_src_o | output | 6 | Sticky per-source status |

## Verification
The hardest corners sit where the mode code, the qualifiers and the access type cross. Examples are a data read that passes the slot 1 qualifier while range mode is on, a masked address that differs from the reference only in masked-off bits, and illegal codes that must silence both shared slots. The bench reaches these by sweeping every mode code and every qualifier value against fetches, reads and writes at four chosen addresses, with a status clear between points. A separate test lines up a clear write and a matching fetch in the same cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int N_SRC  = 6;
  localparam int CTRL_W = 13;

  localparam int REG_CTRL = 0;
  localparam int REG_PA0  = 1;
  localparam int REG_PA1  = 2;
  localparam int REG_C0   = 3;
  localparam int REG_C1   = 4;
  localparam int REG_CLR  = 5;

  localparam int EN_LSB   = 0;
  localparam int FLOW_BIT = 4;
  localparam int STEP_BIT = 5;
  localparam int MODE_LSB = 6;
  localparam int Q0_LSB   = 9;
  localparam int Q1_LSB   = 11;

  localparam logic [2:0] MODE_PP = 3'd0;
  localparam logic [2:0] MODE_PD = 3'd1;
  localparam logic [2:0] MODE_DD = 3'd2;
  localparam logic [2:0] MODE_RP = 3'd3;
  localparam logic [2:0] MODE_RD = 3'd4;

  localparam int SRC_PA0  = 0;
  localparam int SRC_PA1  = 1;
  localparam int SRC_C0   = 2;
  localparam int SRC_C1   = 3;
  localparam int SRC_FLOW = 4;
  localparam int SRC_STEP = 5;

  typedef struct packed {
    logic [1:0] c_prog;
    logic [1:0] c_data;
    logic       rng_prog;
    logic       rng_data;
  } slot_sel_t;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int W = 17
) (
  input  logic         valid_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  assign hit_o = valid_i && (((addr_i ^ ref_i) & mask_i) == '0);
endmodule

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int PA_W   = 17,
  parameter int REG_AW = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [PA_W-1:0]       wdata_i,
  output logic [1:0][PA_W-1:0]  pa_ref_o,
  output logic [1:0][PA_W-1:0]  c_ref_o,
  output logic [3:0]            en_o,
  output logic                  flow_en_o,
  output logic                  step_en_o,
  output logic [1:0][1:0]       qual_o,
  output slot_sel_t             sel_o,
  output logic [N_SRC-1:0]      clr_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [2:0]        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      pa_ref_o <= '0;
      c_ref_o  <= '0;
    end else if (we_i) begin
      if (addr_i == REG_AW'(REG_CTRL)) ctrl_q      <= wdata_i[CTRL_W-1:0];
      if (addr_i == REG_AW'(REG_PA0))  pa_ref_o[0] <= wdata_i;
      if (addr_i == REG_AW'(REG_PA1))  pa_ref_o[1] <= wdata_i;
      if (addr_i == REG_AW'(REG_C0))   c_ref_o[0]  <= wdata_i;
      if (addr_i == REG_AW'(REG_C1))   c_ref_o[1]  <= wdata_i;
    end
  end

  assign clr_o = (we_i && addr_i == REG_AW'(REG_CLR)) ? wdata_i[N_SRC-1:0] : '0;

  assign en_o      = ctrl_q[EN_LSB +: 4];
  assign flow_en_o = ctrl_q[FLOW_BIT];
  assign step_en_o = ctrl_q[STEP_BIT];
  assign qual_o[0] = ctrl_q[Q0_LSB +: 2];
  assign qual_o[1] = ctrl_q[Q1_LSB +: 2];
  assign mode      = ctrl_q[MODE_LSB +: 3];

  // codes above MODE_RD leave both shared slots unused
  always_comb begin
    sel_o = '0;
    case (mode)
      MODE_PP: sel_o.c_prog = 2'b11;
      MODE_PD: begin
        sel_o.c_prog = 2'b01;
        sel_o.c_data = 2'b10;
      end
      MODE_DD: sel_o.c_data   = 2'b11;
      MODE_RP: sel_o.rng_prog = 1'b1;
      MODE_RD: sel_o.rng_data = 1'b1;
      default: sel_o = '0;
    endcase
  end

  p_range_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o.rng_prog || sel_o.rng_data) |-> (sel_o.c_prog == 2'b00 && sel_o.c_data == 2'b00));
  p_one_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_o.rng_prog, sel_o.rng_data}));
  p_slot_kind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o.c_prog & sel_o.c_data) == 2'b00);
endmodule

// File: rtl/brk_flag.sv
module brk_flag #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  // hit beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | hit_i;
  end

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == '0 && clr_i == '0) |=> $stable(status_o));
  p_hit_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((status_o & $past(hit_i)) == $past(hit_i)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == '0 && clr_i != '0) |=> ((status_o & $past(clr_i)) == '0));
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int PA_W   = 17,
  parameter int DA_W   = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [PA_W-1:0]   cfg_wdata_i,
  input  logic              fetch_valid_i,
  input  logic [PA_W-1:0]   fetch_addr_i,
  input  logic              exec_valid_i,
  input  logic              exec_flow_i,
  input  logic              dacc_valid_i,
  input  logic              dacc_we_i,
  input  logic [DA_W-1:0]   dacc_addr_i,
  output logic              brk_o,
  output logic [N_SRC-1:0]  brk_src_o
);
  logic [1:0][PA_W-1:0] pa_ref, c_ref;
  logic [3:0]           en;
  logic                 flow_en, step_en;
  logic [1:0][1:0]      qual;
  slot_sel_t            sel;
  logic [N_SRC-1:0]     clr, hit;
  logic [1:0]           pa_hit, cp_hit, cd_hit, q_ok;
  logic                 rp_hit, rd_hit;

  brk_cfg #(.PA_W(PA_W), .REG_AW(REG_AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .pa_ref_o(pa_ref), .c_ref_o(c_ref), .en_o(en),
    .flow_en_o(flow_en), .step_en_o(step_en),
    .qual_o(qual), .sel_o(sel), .clr_o(clr)
  );

  for (genvar i = 0; i < 2; i++) begin : g_slot
    brk_cmp #(.W(PA_W)) u_pa (
      .valid_i(fetch_valid_i), .addr_i(fetch_addr_i),
      .ref_i(pa_ref[i]), .mask_i({PA_W{1'b1}}), .hit_o(pa_hit[i])
    );
    brk_cmp #(.W(PA_W)) u_cp (
      .valid_i(fetch_valid_i), .addr_i(fetch_addr_i),
      .ref_i(c_ref[i]), .mask_i({PA_W{1'b1}}), .hit_o(cp_hit[i])
    );
    brk_cmp #(.W(DA_W)) u_cd (
      .valid_i(dacc_valid_i), .addr_i(dacc_addr_i),
      .ref_i(c_ref[i][DA_W-1:0]), .mask_i({DA_W{1'b1}}), .hit_o(cd_hit[i])
    );
    assign q_ok[i] = dacc_we_i ? qual[i][1] : qual[i][0];
  end

  brk_cmp #(.W(PA_W)) u_rng_p (
    .valid_i(fetch_valid_i), .addr_i(fetch_addr_i),
    .ref_i(c_ref[0]), .mask_i(c_ref[1]), .hit_o(rp_hit)
  );
  brk_cmp #(.W(DA_W)) u_rng_d (
    .valid_i(dacc_valid_i), .addr_i(dacc_addr_i),
    .ref_i(c_ref[0][DA_W-1:0]), .mask_i(c_ref[1][DA_W-1:0]), .hit_o(rd_hit)
  );

  always_comb begin
    hit           = '0;
    hit[SRC_PA0]  = en[0] && pa_hit[0];
    hit[SRC_PA1]  = en[1] && pa_hit[1];
    hit[SRC_C0]   = en[2] && ((sel.c_prog[0] && cp_hit[0]) ||
                              (sel.c_data[0] && cd_hit[0] && q_ok[0]) ||
                              (sel.rng_prog && rp_hit) ||
                              (sel.rng_data && rd_hit && q_ok[0]));
    hit[SRC_C1]   = en[3] && ((sel.c_prog[1] && cp_hit[1]) ||
                              (sel.c_data[1] && cd_hit[1] && q_ok[1]));
    hit[SRC_FLOW] = flow_en && exec_valid_i && exec_flow_i;
    hit[SRC_STEP] = step_en && exec_valid_i;
  end

  brk_flag #(.N(N_SRC)) u_flag (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr), .status_o(brk_src_o)
  );

  assign brk_o = |brk_src_o;

  p_pa0_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && en[0] && fetch_addr_i == pa_ref[0]) |=> brk_src_o[SRC_PA0]);
  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_i && step_en) |=> brk_src_o[SRC_STEP]);
  p_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en[3] && !brk_src_o[SRC_C1]) |=> !brk_src_o[SRC_C1]);
  p_range_c1_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel.rng_prog || sel.rng_data) && !brk_src_o[SRC_C1]) |=> !brk_src_o[SRC_C1]);
endmodule

// File: tb/brk_unit_test.sv
module brk_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [16:0] cfg_wdata = '0;
  logic        fv = 1'b0, ev = 1'b0, ef = 1'b0, dv = 1'b0, dwe = 1'b0;
  logic [16:0] fa = '0;
  logic [15:0] da = '0;
  logic        brk;
  logic [5:0]  src;
  int          total = 0, bad = 0;

  logic [12:0] m_ctrl = '0;
  logic [16:0] m_pa0 = '0, m_pa1 = '0, m_c0 = '0, m_c1 = '0;

  always #5 clk = ~clk;

  brk_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .fetch_valid_i(fv), .fetch_addr_i(fa),
    .exec_valid_i(ev), .exec_flow_i(ef),
    .dacc_valid_i(dv), .dacc_we_i(dwe), .dacc_addr_i(da),
    .brk_o(brk), .brk_src_o(src)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [16:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: m_ctrl = d[12:0];
      1: m_pa0 = d;
      2: m_pa1 = d;
      3: m_c0 = d;
      4: m_c1 = d;
      default: ;
    endcase
  endtask

  task automatic strobe(input logic f, input logic [16:0] fad, input logic d,
                        input logic w, input logic [15:0] dad, input logic e, input logic fl);
    @(negedge clk);
    fv = f; fa = fad; dv = d; dwe = w; da = dad; ev = e; ef = fl;
    @(negedge clk);
    fv = 0; dv = 0; ev = 0; ef = 0; dwe = 0;
  endtask

  function automatic logic [5:0] model(input logic f, input logic [16:0] fad, input logic d,
                                       input logic w, input logic [15:0] dad,
                                       input logic e, input logic fl);
    logic [5:0] r;
    logic [2:0] mode;
    logic [1:0] q0, q1;
    logic       ok0, ok1;
    r = '0;
    mode = m_ctrl[8:6]; q0 = m_ctrl[10:9]; q1 = m_ctrl[12:11];
    ok0 = w ? q0[1] : q0[0];
    ok1 = w ? q1[1] : q1[0];
    r[0] = m_ctrl[0] && f && fad == m_pa0;
    r[1] = m_ctrl[1] && f && fad == m_pa1;
    if (m_ctrl[2]) case (mode)
      3'd0, 3'd1: r[2] = f && fad == m_c0;
      3'd2:       r[2] = d && ok0 && dad == m_c0[15:0];
      3'd3:       r[2] = f && ((fad & m_c1) == (m_c0 & m_c1));
      3'd4:       r[2] = d && ok0 && ((dad & m_c1[15:0]) == (m_c0[15:0] & m_c1[15:0]));
      default:    r[2] = 1'b0;
    endcase
    if (m_ctrl[3]) case (mode)
      3'd0:       r[3] = f && fad == m_c1;
      3'd1, 3'd2: r[3] = d && ok1 && dad == m_c1[15:0];
      default:    r[3] = 1'b0;
    endcase
    r[4] = m_ctrl[4] && e && fl;
    r[5] = m_ctrl[5] && e;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [16:0] addrs [4];
    logic [5:0]  exp;
    addrs[0] = 17'h01230; addrs[1] = 17'h1FFF0; addrs[2] = 17'h01237; addrs[3] = 17'h02230;

    repeat (3) @(negedge clk);
    chk("R1 src in reset", src, 6'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 src after reset", src, 6'h00);
    chk("R1 brk after reset", {5'b0, brk}, 6'h00);
    // registers reset to zero and disabled: a fetch at 0 must not break
    strobe(1, 17'h0, 1, 0, 16'h0, 1, 1);
    chk("R1 disabled after reset", src, 6'h00);

    // R2 / R11: fixed comparators and latency
    wr(1, 17'h00100);
    wr(2, 17'h1ABCD);
    wr(0, 13'h003);
    @(negedge clk);
    fv = 1; fa = 17'h00100;
    #1 chk("R11 no break before edge", src, 6'h00);
    @(negedge clk);
    fv = 0;
    chk("R11 break one clock after strobe", src, 6'h01);
    chk("R9 brk follows status", {5'b0, brk}, 6'h01);
    repeat (3) @(negedge clk);
    chk("R9 sticky", src, 6'h01);
    strobe(1, 17'h1ABCD, 0, 0, 16'h0, 0, 0);
    chk("R2 pa1 hit", src, 6'h03);
    wr(5, 17'h00001);
    chk("R9 partial clear", src, 6'h02);
    wr(5, 17'h1FFFF);
    chk("R9 full clear", src, 6'h00);
    chk("R9 brk low", {5'b0, brk}, 6'h00);
    strobe(1, 17'h00101, 0, 0, 16'h0, 0, 0);
    chk("R2 off by one", src, 6'h00);

    // R7: disable pa1, keep pa0
    wr(0, 13'h001);
    strobe(1, 17'h1ABCD, 0, 0, 16'h0, 0, 0);
    chk("R7 pa1 disabled", src, 6'h00);

    // R8 flow and step
    wr(0, 13'h010);
    strobe(0, 17'h0, 0, 0, 16'h0, 1, 0);
    chk("R8 sequential no flow break", src, 6'h00);
    strobe(0, 17'h0, 0, 0, 16'h0, 1, 1);
    chk("R8 flow break", src, 6'h10);
    wr(5, 17'h1FFFF);
    wr(0, 13'h020);
    strobe(0, 17'h0, 0, 0, 16'h0, 0, 1);
    chk("R8 no step without exec", src, 6'h00);
    strobe(0, 17'h0, 0, 0, 16'h0, 1, 0);
    chk("R8 step break", src, 6'h20);

    // R10: clear and hit on the same edge
    wr(0, 13'h021);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = 17'h1FFFF;
    fv = 1; fa = 17'h00100;
    @(negedge clk);
    cfg_we = 0; fv = 0;
    chk("R10 hit wins over clear", src, 6'h01);
    wr(5, 17'h1FFFF);

    // R7: shared slot 0 disabled, slot 1 enabled in program mode
    wr(3, addrs[0]);
    wr(4, addrs[1]);
    wr(0, 13'h008);
    strobe(1, addrs[0], 0, 0, 16'h0, 0, 0);
    chk("R7 slot0 disabled", src, 6'h00);
    strobe(1, addrs[1], 0, 0, 16'h0, 0, 0);
    chk("R4 slot1 program", src, 6'h08);
    wr(5, 17'h1FFFF);

    // R3-R6 sweep: mode x qualifier x access kind x address
    for (int mode = 0; mode < 8; mode++) begin
      for (int q = 0; q < 4; q++) begin
        wr(0, 17'({2'(3 - q), 2'(q), 3'(mode), 6'b001100}));
        for (int kind = 0; kind < 3; kind++) begin
          for (int ai = 0; ai < 4; ai++) begin
            if (kind == 0) begin
              exp = model(1, addrs[ai], 0, 0, 16'h0, 0, 0);
              strobe(1, addrs[ai], 0, 0, 16'h0, 0, 0);
            end else begin
              exp = model(0, 17'h0, 1, kind == 2, addrs[ai][15:0], 0, 0);
              strobe(0, 17'h0, 1, kind == 2, addrs[ai][15:0], 0, 0);
            end
            if (mode > 4)       chk("R3 illegal mode", src, exp);
            else if (mode > 2)  chk("R6 range", src, exp);
            else if (kind == 0) chk("R4 program slot", src, exp);
            else                chk("R5 data slot", src, exp);
            chk("R9 brk vs status", {5'b0, brk}, {5'b0, |exp});
            wr(5, 17'h1FFFF);
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule